// File: doc/BRIEF.md
# Block-List Scratchpad DMA Engine

This engine moves data between a processing element's local scratchpad and remote memory, one word at a time, without help from the processor. A command picks a direction. A fetch copies remote words into the scratchpad, and a store copies scratchpad words out to remote memory. A command names either one block directly or a chain of blocks. For a single block, the command carries a scratchpad address, a remote address and a byte count. For a chain, it carries the scratchpad address of a descriptor table and the number of entries in that table.

The engine reads the descriptors from the scratchpad through the same port it uses for data. It runs the entries strictly in table order. Each memory side has its own request channel with valid/ready handshaking. A request holds its address, write flag and write data unchanged until ready is seen high on a rising clock edge. Only one request is outstanding at a time. A read is answered by exactly one response pulse, which arrives in order, and the engine always accepts it. Back-pressure may be applied on any cycle, and it only stretches the transfer.

At the end of every command, accepted or rejected, the engine raises a one-cycle `done`. When the command was refused or aborted, `err` rises in that same cycle.

Top module: `dma_list_engine`

## Requirements
- R1: A command is taken on a rising edge where `cmd_valid` is high and `busy` is low. `cmd_valid` while `busy` is high is ignored. `busy` goes high in the cycle after acceptance, stays high through the `done` cycle, and is low in the cycle after `done`.
- R2: With `cmd_put`=0 (fetch), the engine reads remote words from the remote address upward in steps of 4 bytes. It writes them in the same order to the scratchpad, starting at the local address.
- R3: With `cmd_put`=1 (store), the scratchpad is the source at the local address and remote memory is the destination at the remote address. The words keep their ascending order.
- R4: A block is refused if any of these holds: its byte count is zero, its byte count exceeds MAX_BLK_BYTES (16384 by default), its byte count is not a multiple of 4, either address is not a multiple of 4, or either address does not fit in AW bits. A refused single block gives `done` with `err` and issues no memory request.
- R5: For a chain command (`cmd_list`=1), `cmd_laddr` is the table base and `cmd_size` is the entry count. A count below 2 or above MAX_LIST (2048 by default), or a base that is not a multiple of 4, ends the command with `err` and issues no request.
- R6: Entry i of a table occupies three scratchpad words starting at byte base+12*i: first the remote address, then the local address, then the byte count. Entries are fetched and transferred one after another in index order.
- R7: An entry that breaks the R4 rules stops the chain with `err`. Earlier entries have already been fully transferred. That entry and all later ones produce no data request.
- R8: While a request is valid and ready is low, the request stays unchanged on the following cycle. Each block produces exactly size/4 reads and size/4 writes, with no word lost or repeated.
- R9: `done` is a single-cycle pulse. It follows the acceptance of the last write of the last entry, or the rejection. `err` is high only together with `done`.
- R10: The two request channels are never valid in the same cycle, and neither is valid while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_put | input | 1 | 0 fetch (remote to local), 1 store (local to remote) |
| cmd_list | input | 1 | 0 single block, 1 descriptor chain |
| cmd_laddr | input | AW | Local block address, or table base for a chain |
| cmd_raddr | input | AW | Remote block address (unused for a chain) |
| cmd_size | input | AW | Byte count, or entry count for a chain |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused or aborted, valid with done |
| l_req_valid | output | 1 | Scratchpad request valid |
| l_req_ready | input | 1 | Scratchpad request accepted |
| l_req_we | output | 1 | Scratchpad request is a write |
| l_req_addr | output | AW | Scratchpad byte address |
| l_req_wdata | output | DW | Scratchpad write data |
| l_rsp_valid | input | 1 | Scratchpad read data valid |
| l_rsp_rdata | input | DW | Scratchpad read data |
| r_req_valid | output | 1 | Remote request valid |
| r_req_ready | input | 1 | Remote request accepted |
| r_req_we | output | 1 | Remote request is a write |
| r_req_addr | output | AW | Remote byte address |
| r_req_wdata | output | DW | Remote write data |
| r_rsp_valid | input | 1 | Remote read data valid |
| r_rsp_rdata | input | DW | Remote read data |

## Verification
The bench builds the engine with AW=16 and DW=32, but lowers MAX_BLK_BYTES to 64 and MAX_LIST to 4. With these values, both sides of each limit can be hit in a few dozen cycles. A 64-byte block is accepted and a 68-byte one is refused. A four-entry chain runs, while chains of five entries and of one entry are refused. Transfers run both with ready held high and with ready driven by pseudo-random back-pressure. The bench tallies every read and write handshake, so lost or repeated words show up in the counts.

// File: rtl/dma_list_pkg.sv
package dma_list_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_CHECK, S_RD, S_RWAIT, S_WR, S_FIN
  } dma_state_e;
  localparam int DESC_WORDS = 3;
endpackage

// File: rtl/dma_blk_check.sv
module dma_blk_check #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int MAX_BYTES = 16384
) (
  input  logic [DW-1:0] laddr,
  input  logic [DW-1:0] raddr,
  input  logic [DW-1:0] size,
  output logic          ok
);
  localparam int WB  = DW / 8;
  localparam int ALB = $clog2(WB);

  logic fits_l, fits_r, aligned, size_ok;
  always_comb begin
    fits_l  = (laddr >> AW) == '0;
    fits_r  = (raddr >> AW) == '0;
    aligned = (laddr[ALB-1:0] == '0) && (raddr[ALB-1:0] == '0) && (size[ALB-1:0] == '0);
    size_ok = (size != '0) && (size <= DW'(MAX_BYTES));
    ok      = fits_l && fits_r && aligned && size_ok;
  end
endmodule

// File: rtl/dma_list_check.sv
module dma_list_check #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int MIN_LIST = 2,
  parameter int MAX_LIST = 2048
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] count,
  output logic          ok
);
  localparam int ALB = $clog2(DW / 8);
  always_comb
    ok = (base[ALB-1:0] == '0) && (count >= AW'(MIN_LIST)) && (count <= AW'(MAX_LIST));
endmodule

// File: rtl/dma_port_drive.sv
module dma_port_drive #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter bit IS_LOCAL = 1'b1
) (
  input  logic          rq_valid,
  input  logic          rq_local,
  input  logic          rq_we,
  input  logic [AW-1:0] rq_addr,
  input  logic [DW-1:0] rq_wdata,
  output logic          req_valid,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata
);
  logic sel;
  always_comb begin
    sel       = rq_valid && (rq_local == IS_LOCAL);
    req_valid = sel;
    req_we    = sel && rq_we;
    req_addr  = sel ? rq_addr  : '0;
    req_wdata = sel ? rq_wdata : '0;
  end
endmodule

// File: rtl/dma_list_engine.sv
module dma_list_engine
  import dma_list_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int MAX_BLK_BYTES = 16384,
  parameter int MIN_LIST = 2,
  parameter int MAX_LIST = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_put,
  input  logic          cmd_list,
  input  logic [AW-1:0] cmd_laddr,
  input  logic [AW-1:0] cmd_raddr,
  input  logic [AW-1:0] cmd_size,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          l_req_valid,
  input  logic          l_req_ready,
  output logic          l_req_we,
  output logic [AW-1:0] l_req_addr,
  output logic [DW-1:0] l_req_wdata,
  input  logic          l_rsp_valid,
  input  logic [DW-1:0] l_rsp_rdata,
  output logic          r_req_valid,
  input  logic          r_req_ready,
  output logic          r_req_we,
  output logic [AW-1:0] r_req_addr,
  output logic [DW-1:0] r_req_wdata,
  input  logic          r_rsp_valid,
  input  logic [DW-1:0] r_rsp_rdata
);
  localparam int WB = DW / 8;
  localparam logic [1:0] LAST_DW = 2'(DESC_WORDS - 1);

  dma_state_e    state;
  logic          put_q, err_q;
  logic [DW-1:0] lcur, rcur, rem, data_q;
  logic [AW-1:0] dptr, ents;
  logic [1:0]    dk;

  logic          blk_ok, list_ok;
  logic          rq_valid, rq_local, rq_we, rq_ready;
  logic [AW-1:0] rq_addr;
  logic          src_rsp_valid;
  logic [DW-1:0] src_rdata;

  dma_blk_check #(.AW(AW), .DW(DW), .MAX_BYTES(MAX_BLK_BYTES)) u_blk (
    .laddr(lcur), .raddr(rcur), .size(rem), .ok(blk_ok));

  dma_list_check #(.AW(AW), .DW(DW), .MIN_LIST(MIN_LIST), .MAX_LIST(MAX_LIST)) u_list (
    .base(cmd_laddr), .count(cmd_size), .ok(list_ok));

  // Request steering: descriptor reads always go local; data reads use the source side.
  always_comb begin
    rq_valid = 1'b0;
    rq_local = 1'b1;
    rq_we    = 1'b0;
    rq_addr  = '0;
    unique case (state)
      S_DREQ: begin rq_valid = 1'b1; rq_addr = dptr; end
      S_RD: begin
        rq_valid = 1'b1;
        rq_local = put_q;
        rq_addr  = put_q ? lcur[AW-1:0] : rcur[AW-1:0];
      end
      S_WR: begin
        rq_valid = 1'b1;
        rq_local = !put_q;
        rq_we    = 1'b1;
        rq_addr  = put_q ? rcur[AW-1:0] : lcur[AW-1:0];
      end
      default: ;
    endcase
    rq_ready      = rq_local ? l_req_ready : r_req_ready;
    src_rsp_valid = put_q ? l_rsp_valid : r_rsp_valid;
    src_rdata     = put_q ? l_rsp_rdata : r_rsp_rdata;
  end

  logic [1:0]    side_valid, side_we;
  logic [AW-1:0] side_addr  [2];
  logic [DW-1:0] side_wdata [2];

  for (genvar g = 0; g < 2; g++) begin : g_side
    dma_port_drive #(.AW(AW), .DW(DW), .IS_LOCAL(g == 0)) u_drv (
      .rq_valid(rq_valid), .rq_local(rq_local), .rq_we(rq_we),
      .rq_addr(rq_addr), .rq_wdata(data_q),
      .req_valid(side_valid[g]), .req_we(side_we[g]),
      .req_addr(side_addr[g]), .req_wdata(side_wdata[g]));
  end

  assign l_req_valid = side_valid[0];
  assign l_req_we    = side_we[0];
  assign l_req_addr  = side_addr[0];
  assign l_req_wdata = side_wdata[0];
  assign r_req_valid = side_valid[1];
  assign r_req_we    = side_we[1];
  assign r_req_addr  = side_addr[1];
  assign r_req_wdata = side_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      put_q  <= 1'b0;
      err_q  <= 1'b0;
      lcur   <= '0;
      rcur   <= '0;
      rem    <= '0;
      data_q <= '0;
      dptr   <= '0;
      ents   <= '0;
      dk     <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          put_q <= cmd_put;
          err_q <= 1'b0;
          dk    <= '0;
          if (cmd_list) begin
            dptr <= cmd_laddr;
            ents <= cmd_size;
            if (list_ok) state <= S_DREQ;
            else begin err_q <= 1'b1; state <= S_FIN; end
          end else begin
            lcur  <= DW'(cmd_laddr);
            rcur  <= DW'(cmd_raddr);
            rem   <= DW'(cmd_size);
            ents  <= '0;
            state <= S_CHECK;
          end
        end
        S_DREQ: if (rq_ready) begin
          dptr  <= dptr + AW'(WB);
          state <= S_DWAIT;
        end
        S_DWAIT: if (l_rsp_valid) begin
          unique case (dk)
            2'd0:    rcur <= l_rsp_rdata;
            2'd1:    lcur <= l_rsp_rdata;
            default: rem  <= l_rsp_rdata;
          endcase
          if (dk == LAST_DW) begin
            dk    <= '0;
            ents  <= ents - 1'b1;
            state <= S_CHECK;
          end else begin
            dk    <= dk + 1'b1;
            state <= S_DREQ;
          end
        end
        S_CHECK: if (blk_ok) state <= S_RD;
                 else begin err_q <= 1'b1; state <= S_FIN; end
        S_RD: if (rq_ready) state <= S_RWAIT;
        S_RWAIT: if (src_rsp_valid) begin
          data_q <= src_rdata;
          state  <= S_WR;
        end
        S_WR: if (rq_ready) begin
          lcur <= lcur + DW'(WB);
          rcur <= rcur + DW'(WB);
          rem  <= rem - DW'(WB);
          if (rem == DW'(WB)) state <= (ents != '0) ? S_DREQ : S_FIN;
          else                state <= S_RD;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
  assign err  = done && err_q;

  // R1: busy persists until the done cycle, then drops
  a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  a_r1_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: requests stay put under back-pressure
  a_r8_l_stable: assert property (@(posedge clk) disable iff (!rst_n)
    l_req_valid && !l_req_ready |=> l_req_valid && $stable(l_req_addr)
      && $stable(l_req_we) && $stable(l_req_wdata));
  a_r8_r_stable: assert property (@(posedge clk) disable iff (!rst_n)
    r_req_valid && !r_req_ready |=> r_req_valid && $stable(r_req_addr)
      && $stable(r_req_we) && $stable(r_req_wdata));
  // R10: one channel at a time, silence when idle
  a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_req_valid && r_req_valid));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !l_req_valid && !r_req_valid);
endmodule

// File: tb/dma_list_engine_tb.sv
module dma_list_engine_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_put = 1'b0, cmd_list = 1'b0;
  logic [AW-1:0] cmd_laddr = '0, cmd_raddr = '0, cmd_size = '0;
  logic          busy, done, err;
  logic          l_req_valid, l_req_ready, l_req_we, l_rsp_valid;
  logic [AW-1:0] l_req_addr;
  logic [DW-1:0] l_req_wdata, l_rsp_rdata;
  logic          r_req_valid, r_req_ready, r_req_we, r_rsp_valid;
  logic [AW-1:0] r_req_addr;
  logic [DW-1:0] r_req_wdata, r_rsp_rdata;

  dma_list_engine #(.AW(AW), .DW(DW), .MAX_BLK_BYTES(64), .MIN_LIST(2), .MAX_LIST(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_put(cmd_put), .cmd_list(cmd_list),
    .cmd_laddr(cmd_laddr), .cmd_raddr(cmd_raddr), .cmd_size(cmd_size),
    .busy(busy), .done(done), .err(err),
    .l_req_valid(l_req_valid), .l_req_ready(l_req_ready), .l_req_we(l_req_we),
    .l_req_addr(l_req_addr), .l_req_wdata(l_req_wdata),
    .l_rsp_valid(l_rsp_valid), .l_rsp_rdata(l_rsp_rdata),
    .r_req_valid(r_req_valid), .r_req_ready(r_req_ready), .r_req_we(r_req_we),
    .r_req_addr(r_req_addr), .r_req_wdata(r_req_wdata),
    .r_rsp_valid(r_rsp_valid), .r_rsp_rdata(r_rsp_rdata));

  // ---------------- memory models ----------------
  logic [DW-1:0] lmem [1024];
  logic [DW-1:0] rmem [1024];
  logic [15:0]   lfsr = 16'hACE1;
  logic          bp = 1'b0, do_init = 1'b0, do_poke = 1'b0;
  logic [9:0]    poke_idx = '0;
  logic [DW-1:0] poke_data = '0;
  int wr_l = 0, wr_r = 0, rd_l = 0, rd_r = 0;

  function automatic logic [DW-1:0] lpat(int i); return 32'hA000_0000 + 32'(i); endfunction
  function automatic logic [DW-1:0] rpat(int i); return 32'hB000_0000 + 32'(i); endfunction

  assign l_req_ready = bp ? lfsr[0] : 1'b1;
  assign r_req_ready = bp ? lfsr[5] : 1'b1;

  always @(posedge clk) begin
    lfsr        <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    l_rsp_valid <= 1'b0;
    r_rsp_valid <= 1'b0;
    if (do_init) begin
      for (int i = 0; i < 1024; i++) begin lmem[i] <= lpat(i); rmem[i] <= rpat(i); end
    end else if (do_poke) begin
      lmem[poke_idx] <= poke_data;
    end else begin
      if (l_req_valid && l_req_ready) begin
        if (l_req_we) begin lmem[l_req_addr[11:2]] <= l_req_wdata; wr_l <= wr_l + 1; end
        else begin l_rsp_valid <= 1'b1; l_rsp_rdata <= lmem[l_req_addr[11:2]]; rd_l <= rd_l + 1; end
      end
      if (r_req_valid && r_req_ready) begin
        if (r_req_we) begin rmem[r_req_addr[11:2]] <= r_req_wdata; wr_r <= wr_r + 1; end
        else begin r_rsp_valid <= 1'b1; r_rsp_rdata <= rmem[r_req_addr[11:2]]; rd_r <= rd_r + 1; end
      end
    end
  end

  // ---------------- checking helpers ----------------
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    @(negedge clk); do_init = 1'b1;
    @(negedge clk); do_init = 1'b0;
  endtask

  task automatic poke(input int idx, input logic [DW-1:0] d);
    @(negedge clk); do_poke = 1'b1; poke_idx = 10'(idx); poke_data = d;
    @(negedge clk); do_poke = 1'b0;
  endtask

  task automatic put_desc(input int base, input int i, input int ra, input int la, input int sz);
    poke(base / 4 + 3 * i,     32'(ra));
    poke(base / 4 + 3 * i + 1, 32'(la));
    poke(base / 4 + 3 * i + 2, 32'(sz));
  endtask

  task automatic issue(input bit put, input bit lst, input int la, input int ra, input int sz);
    @(negedge clk);
    cmd_put = put; cmd_list = lst;
    cmd_laddr = AW'(la); cmd_raddr = AW'(ra); cmd_size = AW'(sz);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R1 busy after accept", 32'(busy), 32'd1);
  endtask

  task automatic wait_done(output bit e);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R9 done seen", 32'(done), 32'd1);
    e = err;
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle then idle", {30'd0, done, busy}, 32'd0);
  endtask

  function automatic int writes(); return wr_l + wr_r; endfunction
  function automatic int reads();  return rd_l + rd_r; endfunction

  // ---------------- single-block vector table ----------------
  typedef struct packed {
    logic        put;
    logic        bpe;
    logic [15:0] la;
    logic [15:0] ra;
    logic [15:0] sz;
    logic        xerr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 16'h0100, 16'h0200, 16'd16, 1'b0},  // R2 fetch
    '{1'b1, 1'b0, 16'h0140, 16'h0300, 16'd8,  1'b0},  // R3 store
    '{1'b0, 1'b1, 16'h0180, 16'h0400, 16'd64, 1'b0},  // R4 limit, R8 back-pressure
    '{1'b1, 1'b1, 16'h0040, 16'h07FC, 16'd4,  1'b0},  // R3 one word
    '{1'b0, 1'b0, 16'h0100, 16'h0200, 16'd68, 1'b1},  // R4 oversize
    '{1'b1, 1'b0, 16'h0102, 16'h0200, 16'd8,  1'b1},  // R4 local misaligned
    '{1'b0, 1'b0, 16'h0100, 16'h0201, 16'd8,  1'b1},  // R4 remote misaligned
    '{1'b1, 1'b0, 16'h0100, 16'h0200, 16'd6,  1'b1},  // R4 odd size
    '{1'b0, 1'b0, 16'h0100, 16'h0200, 16'd0,  1'b1}   // R4 zero size
  };

  task automatic run_single(input vec_t v);
    bit e;
    int w0, r0, nw, li, ri;
    bp = v.bpe;
    init_mem();
    w0 = writes(); r0 = reads();
    issue(v.put, 1'b0, int'(v.la), int'(v.ra), int'(v.sz));
    wait_done(e);
    chk(e == v.xerr, "R4 err flag", 32'(e), 32'(v.xerr));
    nw = v.xerr ? 0 : int'(v.sz) / 4;
    chk(writes() - w0 == nw, "R8 write count", 32'(writes() - w0), 32'(nw));
    chk(reads() - r0 == nw, "R8 read count", 32'(reads() - r0), 32'(nw));
    li = int'(v.la) / 4; ri = int'(v.ra) / 4;
    if (!v.xerr) begin
      for (int k = 0; k < nw; k++) begin
        if (v.put) chk(rmem[ri + k] == lpat(li + k), "R3 data", rmem[ri + k], lpat(li + k));
        else       chk(lmem[li + k] == rpat(ri + k), "R2 data", lmem[li + k], rpat(ri + k));
      end
      if (v.put) chk(rmem[ri + nw] == rpat(ri + nw), "R8 no extra word", rmem[ri + nw], rpat(ri + nw));
      else       chk(lmem[li + nw] == lpat(li + nw), "R8 no extra word", lmem[li + nw], lpat(li + nw));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    bit e;
    int w0, r0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R1 reset state", {29'd0, busy, done, err}, 32'd0);
    chk(!l_req_valid && !r_req_valid, "R10 reset quiet", {30'd0, l_req_valid, r_req_valid}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_single(VEC[i]);

    // R6 fetch chain of three, back-pressure, plus an ignored command while busy (R1)
    bp = 1'b1;
    init_mem();
    put_desc(32'h800, 0, 32'h200, 32'h100, 8);
    put_desc(32'h800, 1, 32'h300, 32'h120, 12);
    put_desc(32'h800, 2, 32'h400, 32'h180, 4);
    w0 = writes();
    issue(1'b0, 1'b1, 32'h800, 0, 3);
    @(negedge clk);
    cmd_put = 1'b1; cmd_list = 1'b0; cmd_laddr = 16'h0000; cmd_raddr = 16'h0500; cmd_size = 16'd8;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(e);
    chk(e == 1'b0, "R6 chain no err", 32'(e), 32'd0);
    for (int k = 0; k < 2; k++) chk(lmem[32'h40 + k] == rpat(32'h80 + k), "R6 entry0", lmem[32'h40 + k], rpat(32'h80 + k));
    for (int k = 0; k < 3; k++) chk(lmem[32'h48 + k] == rpat(32'hC0 + k), "R6 entry1", lmem[32'h48 + k], rpat(32'hC0 + k));
    chk(lmem[32'h60] == rpat(32'h100), "R6 entry2", lmem[32'h60], rpat(32'h100));
    repeat (3) @(negedge clk);
    chk(!busy, "R1 ignored command left idle", 32'(busy), 32'd0);
    chk(writes() - w0 == 6, "R1 ignored command wrote nothing", 32'(writes() - w0), 32'd6);
    chk(rmem[32'h140] == rpat(32'h140), "R1 ignored store target untouched", rmem[32'h140], rpat(32'h140));

    // R5 store chain at the maximum count of four
    init_mem();
    for (int i = 0; i < 4; i++) put_desc(32'h900, i, 32'h600 + 16 * i, 32'h100 + 16 * i, 4);
    issue(1'b1, 1'b1, 32'h900, 0, 4);
    wait_done(e);
    chk(e == 1'b0, "R5 max count accepted", 32'(e), 32'd0);
    for (int i = 0; i < 4; i++)
      chk(rmem[(32'h600 + 16 * i) / 4] == lpat((32'h100 + 16 * i) / 4), "R3 chain store data",
          rmem[(32'h600 + 16 * i) / 4], lpat((32'h100 + 16 * i) / 4));

    // R5 counts out of range, and misaligned base
    bp = 1'b0;
    w0 = writes(); r0 = reads();
    issue(1'b0, 1'b1, 32'h900, 0, 5);
    wait_done(e);
    chk(e == 1'b1, "R5 count 5 refused", 32'(e), 32'd1);
    issue(1'b0, 1'b1, 32'h900, 0, 1);
    wait_done(e);
    chk(e == 1'b1, "R5 count 1 refused", 32'(e), 32'd1);
    issue(1'b0, 1'b1, 32'h902, 0, 2);
    wait_done(e);
    chk(e == 1'b1, "R5 misaligned base refused", 32'(e), 32'd1);
    chk((writes() - w0) + (reads() - r0) == 0, "R5 no requests", 32'((writes() - w0) + (reads() - r0)), 32'd0);

    // R7 bad second entry aborts after the first completes
    bp = 1'b1;
    init_mem();
    put_desc(32'hA00, 0, 32'h200, 32'h100, 8);
    put_desc(32'hA00, 1, 32'h300, 32'h140, 6);
    put_desc(32'hA00, 2, 32'h400, 32'h180, 4);
    w0 = writes(); r0 = reads();
    issue(1'b0, 1'b1, 32'hA00, 0, 3);
    wait_done(e);
    chk(e == 1'b1, "R7 abort err", 32'(e), 32'd1);
    chk(writes() - w0 == 2, "R7 only first entry written", 32'(writes() - w0), 32'd2);
    chk(reads() - r0 == 8, "R7 six descriptor plus two data reads", 32'(reads() - r0), 32'd8);
    chk(lmem[32'h41] == rpat(32'h81), "R7 first entry data", lmem[32'h41], rpat(32'h81));
    chk(lmem[32'h50] == lpat(32'h50), "R7 bad entry untouched", lmem[32'h50], lpat(32'h50));
    chk(lmem[32'h60] == lpat(32'h60), "R7 later entry untouched", lmem[32'h60], lpat(32'h60));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule